// File: doc/BRIEF.md
# Cascaded Interrupt Occurrence Counter

This block keeps three one-bit sticky interrupt stages that all watch the same event input. They are chained: stage 2 may only hold a value while stage 1 is set, and stage 3 only while stage 2 is set. A single stream of events therefore fills the stages one at a time, and software can tell whether the event happened once, twice, or three or more times.

The enable coming from the previous stage gates the stored value itself, not just the interrupt output. So when software clears an earlier stage, every later stage reads back as cleared and cannot come back. Software reads each stage through a small register window with one address per stage. Writing a one to bit 0 of a stage clears it.

The block drives a combined interrupt line and one halt line per stage. Each halt line can be switched on or off by a parameter.

Top module: `evt_cascade_ctr`

## Requirements
- R1: After reset every stage holds 0, and `irq_o`, `halt_o` and `rdata_o` are all 0.
- R2: An event cycle (`evt_i` high at a rising edge) while stage 1 is clear sets stage 1, visible from that edge on. Stage 1 then stays set while further events arrive.
- R3: Stage k (k = 2 or 3) sets only on an event cycle in which stage k-1 was already visible before the edge. One event cycle therefore sets at most one new stage. The first, second and third event cycles set stages 1, 2 and 3, and later events change nothing.
- R4: `rdata_o` bit 0 returns the visible value of stage 1, 2 or 3 at addresses 0x100, 0x200 and 0x300. All upper bits are 0, and any other address reads 0.
- R5: A cycle with `wr_en_i` high, `addr_i` equal to a stage address and `wr_bit_i` = 1 clears that stage from the edge on. A write with `wr_bit_i` = 0, or to any other address, changes no stage.
- R6: While a stage is clear, every later stage reads 0 and its stored value is dropped. The later stages return only when new events refill them in order.
- R7: If an event and a clear hit the same stage in the same cycle, and the stage is enabled, the stage ends up set.
- R8: `irq_o` is the OR of the three visible stage values.
- R9: `halt_o[i]` equals the visible value of stage i+1 when bit i of `HALT_MASK` is 1, and is 0 otherwise. The default mask is 3'b101.
- R10: The visible stages always form a thermometer code (a set stage implies all earlier stages are set). The number of set stages rises by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 1 | Shared event input, sampled at every edge |
| wr_en_i | input | 1 | Software write strobe |
| addr_i | input | ADDR_W | Software address for both read and write |
| wr_bit_i | input | 1 | Write data bit 0; a 1 clears the addressed stage |
| rdata_o | output | DATA_W | Read data for the address on `addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt |
| halt_o | output | NUM_STAGES | Per-stage halt lines |

## Verification
All stage state changes on the rising edge that samples an event or a write. The bench therefore drives `evt_i` and the write strobe on a falling edge and checks the new state at the following falling edge, exactly one cycle later. Reads are combinational from the stage flops, so the bench changes `addr_i` in the low half of the clock and samples `rdata_o` 1 ns later, never across an edge. `irq_o` and `halt_o` are checked in the same window, because they carry no extra register stage.

// File: rtl/evt_casc_pkg.sv
package evt_casc_pkg;

    localparam int unsigned CASC_STAGES = 3;
    localparam int unsigned CASC_ADDR_W = 12;
    localparam int unsigned CASC_DATA_W = 32;

    // Stored state of one stage.
    typedef struct packed {
        logic held;
    } casc_stage_t;

    // Per-stage control gathered for one cycle.
    typedef struct packed {
        logic evt;
        logic clr;
        logic en;
    } casc_ctl_t;

endpackage

// File: rtl/evt_casc_stage.sv
module evt_casc_stage
    import evt_casc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    input  logic en_i,
    output logic vis_o
);

    casc_stage_t st_d, st_q;
    casc_ctl_t   ctl;
    logic        set_now;
    logic        vis_now;

    always_comb begin
        ctl     = '{evt: evt_i, clr: clr_i, en: en_i};
        vis_now = st_q.held & ctl.en;
        set_now = ctl.evt & ctl.en;
        st_d    = st_q;
        // Set has priority over clear; a disabled stage drops its value.
        st_d.held = set_now | (vis_now & ~ctl.clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vis_o = vis_now;

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vis_o) |-> $past(evt_i && en_i));                     // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i && !evt_i) |-> !vis_o);                         // R5
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt_i && en_i) |-> st_q.held);                        // R7
    AST_NO_REVIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!en_i) |-> !st_q.held);                               // R6

endmodule

// File: rtl/evt_casc_regif.sv
module evt_casc_regif #(
    parameter int unsigned                  NUM_STAGES = 3,
    parameter int unsigned                  ADDR_W     = 12,
    parameter int unsigned                  DATA_W     = 32,
    parameter logic [ADDR_W-1:0]            BASE_ADDR  = 12'h100,
    parameter logic [ADDR_W-1:0]            STRIDE     = 12'h100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_bit_i,
    input  logic [NUM_STAGES-1:0] vis_i,
    output logic [NUM_STAGES-1:0] clr_o,
    output logic [DATA_W-1:0]     rdata_o
);

    logic [NUM_STAGES-1:0] hit;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_dec
        localparam logic [ADDR_W-1:0] STAGE_ADDR = ADDR_W'(BASE_ADDR + STRIDE * i);
        assign hit[i]   = (addr_i == STAGE_ADDR);
        assign clr_o[i] = wr_en_i & hit[i] & wr_bit_i;
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (hit[i]) begin
                rdata_o[0] = vis_i[i];
            end
        end
    end

    AST_DECODE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));                                           // R5
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:1] == '0);                                 // R4

endmodule

// File: rtl/evt_casc_out.sv
module evt_casc_out #(
    parameter int unsigned                  NUM_STAGES = 3,
    parameter logic [NUM_STAGES-1:0]        HALT_MASK  = 3'b101
) (
    input  logic [NUM_STAGES-1:0] vis_i,
    output logic                  irq_o,
    output logic [NUM_STAGES-1:0] halt_o
);

    assign irq_o = |vis_i;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_halt
        if (HALT_MASK[i]) begin : g_on
            assign halt_o[i] = vis_i[i];
        end else begin : g_off
            assign halt_o[i] = 1'b0;
        end
    end

endmodule

// File: rtl/evt_cascade_ctr.sv
module evt_cascade_ctr
    import evt_casc_pkg::*;
#(
    parameter int unsigned                  NUM_STAGES = CASC_STAGES,
    parameter int unsigned                  ADDR_W     = CASC_ADDR_W,
    parameter int unsigned                  DATA_W     = CASC_DATA_W,
    parameter logic [ADDR_W-1:0]            BASE_ADDR  = 12'h100,
    parameter logic [ADDR_W-1:0]            STRIDE     = 12'h100,
    parameter logic [NUM_STAGES-1:0]        HALT_MASK  = 3'b101
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  evt_i,
    input  logic                  wr_en_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wr_bit_i,
    output logic [DATA_W-1:0]     rdata_o,
    output logic                  irq_o,
    output logic [NUM_STAGES-1:0] halt_o
);

    logic [NUM_STAGES-1:0] vis;
    logic [NUM_STAGES-1:0] en;
    logic [NUM_STAGES-1:0] clr;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            assign en[i] = 1'b1;
        end else begin : g_link
            assign en[i] = vis[i-1];
        end
        evt_casc_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (evt_i),
            .clr_i (clr[i]),
            .en_i  (en[i]),
            .vis_o (vis[i])
        );
    end

    evt_casc_regif #(
        .NUM_STAGES (NUM_STAGES),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .BASE_ADDR  (BASE_ADDR),
        .STRIDE     (STRIDE)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wr_bit_i (wr_bit_i),
        .vis_i    (vis),
        .clr_o    (clr),
        .rdata_o  (rdata_o)
    );

    evt_casc_out #(
        .NUM_STAGES (NUM_STAGES),
        .HALT_MASK  (HALT_MASK)
    ) u_out (
        .vis_i  (vis),
        .irq_o  (irq_o),
        .halt_o (halt_o)
    );

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vis) <= $countones($past(vis)) + 1);             // R10
    AST_IRQ_FOLLOWS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == vis[0]);                                           // R8

endmodule

// File: tb/evt_cascade_ctr_bench.sv
`timescale 1ns/100ps
module evt_cascade_ctr_bench;

    localparam logic [2:0] HMASK = 3'b101;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_bit = 1'b0;
    logic [31:0] rdata;
    logic        irq;
    logic [2:0]  halt;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    evt_cascade_ctr u_evt_cascade_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .wr_en_i  (wr_en),
        .addr_i   (addr),
        .wr_bit_i (wr_bit),
        .rdata_o  (rdata),
        .irq_o    (irq),
        .halt_o   (halt)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reads all three stages and checks irq/halt; called in the low clock phase.
    task automatic check_state(input logic [2:0] exp, input string req);
        for (int i = 0; i < 3; i++) begin
            addr = 12'(12'h100 * (i + 1));
            #1;
            chk({req, " R4 read"}, rdata, {31'b0, exp[i]});
        end
        chk({req, " R8 irq"}, {31'b0, irq}, {31'b0, |exp});
        chk({req, " R9 halt"}, {29'b0, halt}, {29'b0, exp & HMASK});
    endtask

    task automatic one_event();
        @(negedge clk) evt = 1'b1;
        @(negedge clk) evt = 1'b0;
    endtask

    task automatic sw_write(input logic [11:0] a, input logic b, input logic with_evt);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_bit = b; evt = with_evt;
        @(negedge clk);
        wr_en = 1'b0; wr_bit = 1'b0; evt = 1'b0;
    endtask

    task automatic clear_all();
        sw_write(12'h100, 1'b1, 1'b0);
        check_state(3'b000, "setup R6");
    endtask

    task automatic t_reset();
        check_state(3'b000, "R1 reset");
        addr = 12'h104; #1;
        chk("R1 R4 unmapped", rdata, 32'h0);
    endtask

    task automatic t_count();
        one_event(); check_state(3'b001, "R2 first event");
        one_event(); check_state(3'b011, "R3 second event");
        one_event(); check_state(3'b111, "R3 third event");
        one_event(); check_state(3'b111, "R3 R2 extra event");
        addr = 12'h300; #1;
        chk("R4 upper bits", rdata, 32'h1);
        addr = 12'h301; #1;
        chk("R4 near address", rdata, 32'h0);
        clear_all();
    endtask

    task automatic t_held();
        @(negedge clk) evt = 1'b1;
        @(negedge clk) check_state(3'b001, "R3 held cycle1");
        @(negedge clk) check_state(3'b011, "R3 held cycle2");
        @(negedge clk) evt = 1'b0;
        check_state(3'b111, "R3 held cycle3");
        clear_all();
    endtask

    task automatic t_clear();
        one_event(); one_event(); one_event();
        sw_write(12'h200, 1'b0, 1'b0);
        check_state(3'b111, "R5 write zero");
        sw_write(12'h204, 1'b1, 1'b0);
        check_state(3'b111, "R5 other address");
        sw_write(12'h300, 1'b1, 1'b0);
        check_state(3'b011, "R5 clear stage3");
        one_event(); check_state(3'b111, "R5 refill");
        sw_write(12'h100, 1'b1, 1'b0);
        check_state(3'b000, "R6 clear head");
        one_event(); check_state(3'b001, "R6 no revive");
        one_event(); one_event();
        sw_write(12'h200, 1'b1, 1'b0);
        check_state(3'b001, "R6 clear middle");
        one_event(); check_state(3'b011, "R6 middle refill");
        clear_all();
    endtask

    task automatic t_collide();
        one_event(); one_event(); one_event();
        sw_write(12'h300, 1'b1, 1'b1);
        check_state(3'b111, "R7 event beats clear stage3");
        clear_all();
        one_event();
        sw_write(12'h100, 1'b1, 1'b1);
        addr = 12'h100; #1;
        chk("R7 event beats clear stage1", rdata, 32'h1);
        clear_all();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_held();
        t_clear();
        t_collide();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule